// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is a countdown timer clocked by the bus clock. Software programs a start count, a clock divide setting and a timer entry made of an interrupt vector, a mask bit and a mode bit. Writing the start count loads it into the live counter and restarts the prescaler. From then on the counter decrements once per prescaled tick until it reaches zero.

Each time the count expires, the block emits a one-cycle request strobe. The strobe carries the programmed vector and is meant for fixed-mode, edge-triggered delivery. If the entry's mask bit is set, the strobe is suppressed but counting carries on. In periodic mode the counter reloads from the start count and keeps running. In one-shot mode it stays at zero until software writes the start count again.

The register port is a simple select/write/read interface. Writes take effect at the clock edge where `wr_en` is high. `rd_data` is a combinational view of the selected register. Select codes: 0 = timer entry, 1 = start count, 2 = live count, 3 = divide setting.

Top module: `tick_countdown_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The divide setting, start count and live count all read 0, and no strobe is issued.
- R2: The divide code is {data bit 3, bit 1, bit 0}. Codes 0 to 6 give a tick every 2, 4, 8, 16, 32, 64 and 128 bus cycles. Code 7 gives a tick on every cycle. A start count N written at edge E expires at edge E + N·P, where P is the tick period.
- R3: Reading the divide setting returns the code in bits 3, 1 and 0 as written. All other bits read as zero.
- R4: Writing the start count loads the live count with the written value and restarts the prescaler from zero, abandoning any count in progress.
- R5: The live count decrements by one per tick and can be read while running without disturbing it. Writes to select 2 are ignored.
- R6: In one-shot mode (entry bit 17 clear), the live count stays at zero after expiry and exactly one strobe is issued.
- R7: In periodic mode (entry bit 17 set), expiry reloads the live count from the start count, so strobes repeat every N·P cycles.
- R8: With the entry mask bit (bit 16) set, expiry issues no strobe while the count still runs down to zero.
- R9: Writing a start count of zero stops the timer with the live count at zero, and no strobe follows.
- R10: The strobe `irq_valid` is high for one cycle, in the cycle after the expiry edge. `irq_vector` then holds the entry's vector bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 entry, 1 start count, 2 live count, 3 divide) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq_valid | output | 1 | One-cycle expiry request strobe |
| irq_vector | output | 8 | Vector accompanying the strobe |

## Verification
The assertions assume that only a start-count write loads the live counter. They also assume that `wr_data` is stable and meaningful whenever `wr_en` is high, and that a mask or mode change takes effect from the next edge. The stimulus keeps to single-cycle writes driven mid-cycle, with every select code in range. It changes the divide setting only before a fresh start-count write, so that each expected expiry edge follows directly from N·P. Stopping a periodic run is done with a zero start-count write placed between two expiries, never on an expiry edge.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types for the countdown timer.
// Assumes a 32-bit register port and an 8-bit vector.
package tick_timer_pkg;
    localparam int DATA_W      = 32;
    localparam int VEC_W       = 8;
    localparam int SEL_W       = 2;
    localparam int DIV_CODE_W  = 3;
    localparam int PRE_W       = 7;  // widest prescale period is 2**PRE_W
    localparam int ENTRY_MASK_BIT = 16;
    localparam int ENTRY_MODE_BIT = 17;

    // data bit position carrying each divide code bit (code bit i -> DIV_POS[i])
    localparam int DIV_POS [DIV_CODE_W] = '{0, 1, 3};

    localparam logic [SEL_W-1:0] SEL_ENTRY = 2'd0;
    localparam logic [SEL_W-1:0] SEL_INIT  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CURR  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_DIV   = 2'd3;

    localparam logic [DIV_CODE_W-1:0] DIV_BY_ONE = 3'd7;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_t;

    localparam entry_t ENTRY_RESET = '{periodic: 1'b0, mask: 1'b1, vector: '0};
endpackage

// File: rtl/tick_timer_regs.sv
// Register file of the countdown timer: timer entry, start count and divide code.
// Produces a load pulse on start-count writes and a combinational read mux.
// Assumes single-cycle write strobes; the live count is supplied from outside.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [CNT_W-1:0]      cur_count,
    output entry_t                entry_q,
    output logic [CNT_W-1:0]      init_q,
    output logic [DIV_CODE_W-1:0] div_code_q,
    output logic                  load_pulse,
    output logic [DATA_W-1:0]     rd_data
);
    logic [DIV_CODE_W-1:0] div_code_next;

    // Write decode for the start count
    always_comb load_pulse = wr_en && (reg_sel == SEL_INIT);

    // Gather the scattered divide code bits from the write data
    always_comb begin
        for (int i = 0; i < DIV_CODE_W; i++) begin
            div_code_next[i] = wr_data[DIV_POS[i]];
        end
    end

    // Register updates; the live-count select has no storage here
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q    <= ENTRY_RESET;
            init_q     <= '0;
            div_code_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                SEL_ENTRY: begin
                    entry_q.periodic <= wr_data[ENTRY_MODE_BIT];
                    entry_q.mask     <= wr_data[ENTRY_MASK_BIT];
                    entry_q.vector   <= wr_data[VEC_W-1:0];
                end
                SEL_INIT: init_q     <= wr_data[CNT_W-1:0];
                SEL_DIV:  div_code_q <= div_code_next;
                default:  ;
            endcase
        end
    end

    // Read mux for the selected register
    always_comb begin
        rd_data = '0;
        unique case (reg_sel)
            SEL_ENTRY: begin
                rd_data[ENTRY_MODE_BIT] = entry_q.periodic;
                rd_data[ENTRY_MASK_BIT] = entry_q.mask;
                rd_data[VEC_W-1:0]      = entry_q.vector;
            end
            SEL_INIT: rd_data = DATA_W'(init_q);
            SEL_CURR: rd_data = DATA_W'(cur_count);
            default: begin
                for (int i = 0; i < DIV_CODE_W; i++) begin
                    rd_data[DIV_POS[i]] = div_code_q[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/tick_timer_prescaler.sv
// Power-of-two prescaler: emits a tick once per 2**(code+1) cycles, or on
// every cycle for the divide-by-one code. Restart clears the phase to zero.
// Assumes a code change mid-run may shorten the current period once.
module tick_timer_prescaler
    import tick_timer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic [DIV_CODE_W-1:0] div_code,
    output logic                  tick
);
    logic [PRE_W:0]   period;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] phase_q;

    // Terminal phase value for the selected divide code
    always_comb begin
        period = (PRE_W+1)'(1) << (div_code + 3'd1);
        limit  = (div_code == DIV_BY_ONE) ? '0 : PRE_W'(period - 1'b1);
    end

    // A tick fires at (or past) the terminal phase
    always_comb tick = (phase_q >= limit);

    // Phase counter with restart on start-count writes
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_timer_counter.sv
// Live countdown register and expiry strobe generator.
// Assumes load has priority over ticking; periodic reload uses the start count.
module tick_timer_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_val,
    input  logic             tick,
    input  entry_t           entry,
    output logic [CNT_W-1:0] cur_q,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    logic expire;

    // Expiry: the last unit of count consumed by a tick, unless reloaded now
    always_comb expire = tick && (cur_q == CNT_W'(1)) && !load;

    // Countdown with load, periodic reload and stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= load_val;
        end else if (tick && (cur_q != '0)) begin
            if (cur_q == CNT_W'(1)) begin
                cur_q <= entry.periodic ? init_val : '0;
            end else begin
                cur_q <= cur_q - 1'b1;
            end
        end
    end

    // Registered request strobe with the vector captured at expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= expire && !entry.mask;
            if (expire) begin
                irq_vector <= entry.vector;
            end
        end
    end
endmodule

// File: rtl/tick_countdown_timer.sv
// Top of the countdown timer: register file, prescaler and countdown core.
// Assumes a single bus clock domain and synchronous active-low reset.
module tick_countdown_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    entry_t                entry;
    logic [CNT_W-1:0]      init_count;
    logic [CNT_W-1:0]      cur_count;
    logic [DIV_CODE_W-1:0] div_code;
    logic                  load_pulse;
    logic                  tick;
    logic                  entry_mask;
    logic                  entry_periodic;

    // Flattened entry fields for observation
    always_comb begin
        entry_mask     = entry.mask;
        entry_periodic = entry.periodic;
    end

    tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_sel    (reg_sel),
        .wr_data    (wr_data),
        .cur_count  (cur_count),
        .entry_q    (entry),
        .init_q     (init_count),
        .div_code_q (div_code),
        .load_pulse (load_pulse),
        .rd_data    (rd_data)
    );

    tick_timer_prescaler u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (load_pulse),
        .div_code (div_code),
        .tick     (tick)
    );

    tick_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_pulse),
        .load_val   (wr_data[CNT_W-1:0]),
        .init_val   (init_count),
        .tick       (tick),
        .entry      (entry),
        .cur_q      (cur_count),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );
endmodule

// File: rtl/tick_timer_checker.sv
// Property checker for the countdown timer, bound to the top module.
// Relates register-port writes, the live count and the strobe over time.
module tick_timer_checker
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  cur_count,
    input logic              entry_mask,
    input logic              entry_periodic,
    input logic              irq_valid
);
    logic init_wr;

    // Start-count write as seen on the port
    always_comb init_wr = wr_en && (reg_sel == SEL_INIT);

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (cur_count == $past(wr_data[CNT_W-1:0])));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count > CNT_W'(1) && !init_wr) |=>
            (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1));

    p_zero_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !init_wr) |=> (cur_count == '0));

    p_oneshot_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !$past(entry_periodic) && !$past(init_wr)) |-> (cur_count == '0));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && $past(entry_periodic)) |-> (cur_count != '0));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(entry_mask));

    p_zero_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_wr && wr_data[CNT_W-1:0] == '0) |=> (!irq_valid && cur_count == '0));
endmodule

bind tick_countdown_timer tick_timer_checker #(.CNT_W(CNT_W)) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .reg_sel        (reg_sel),
    .wr_data        (wr_data),
    .cur_count      (cur_count),
    .entry_mask     (entry_mask),
    .entry_periodic (entry_periodic),
    .irq_valid      (irq_valid)
);

// File: tb/test_tick_countdown_timer.sv
// Scoreboard bench: driver tasks push expected strobes (edge number, vector),
// a monitor at the falling edge pops and compares them.
module test_tick_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int         q_cyc[$];
    logic [7:0] q_vec[$];
    string      q_req[$];

    localparam logic [1:0] S_ENTRY = 2'd0, S_INIT = 2'd1, S_CURR = 2'd2, S_DIV = 2'd3;

    tick_countdown_timer i_tick_countdown_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always #2.5 clk = ~clk;  // 200 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Single-cycle write; returns the edge number where it takes effect
    task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int edge_no);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        edge_no = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        reg_sel = sel;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic expect_irq(input string req, input int at, input logic [7:0] vec);
        q_cyc.push_back(at);
        q_vec.push_back(vec);
        q_req.push_back(req);
    endtask

    task automatic drain;
        while (q_cyc.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // Monitor: compare strobes against the expected queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q_cyc.size() != 0 && q_cyc[0] < cyc) begin
                total++; bad++;
                $display("FAIL %s: missed strobe actual=none expected cycle %0d", q_req[0], q_cyc[0]);
                void'(q_cyc.pop_front()); void'(q_vec.pop_front()); void'(q_req.pop_front());
            end
            if (irq_valid) begin
                total++;
                if (q_cyc.size() == 0) begin
                    bad++;
                    $display("FAIL R6/R8/R9/R10: unexpected strobe actual=cycle %0d expected=none", cyc);
                end else begin
                    if (q_cyc[0] != cyc || q_vec[0] !== irq_vector) begin
                        bad++;
                        $display("FAIL %s: actual cycle %0d vec 0x%02h expected cycle %0d vec 0x%02h",
                                 q_req[0], cyc, irq_vector, q_cyc[0], q_vec[0]);
                    end
                    void'(q_cyc.pop_front()); void'(q_vec.pop_front()); void'(q_req.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e0;
        int e1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1 entry", S_ENTRY, 32'h0001_0000);
        rd_chk("R1 divide", S_DIV, 32'h0);
        rd_chk("R1 start count", S_INIT, 32'h0);
        rd_chk("R1 live count", S_CURR, 32'h0);
        chk("R1 strobe", {31'b0, irq_valid}, 32'h0);

        // R3: divide readback keeps bits 3,1,0 only
        wr(S_DIV, 32'hFFFF_FFFF, e0);
        rd_chk("R3 all ones", S_DIV, 32'h0000_000B);
        wr(S_DIV, 32'h0000_0004, e0);
        rd_chk("R3 bit2 only", S_DIV, 32'h0);
        wr(S_DIV, 32'h0000_000A, e0);
        rd_chk("R3 code 6", S_DIV, 32'h0000_000A);

        // R6/R10: one-shot, divide by one (code 7), vector 0x41
        wr(S_ENTRY, 32'h0000_0041, e0);
        rd_chk("R10 entry readback", S_ENTRY, 32'h0000_0041);
        wr(S_DIV, 32'h0000_000B, e0);
        wr(S_INIT, 32'd5, e0);
        expect_irq("R6 one-shot div1", e0 + 5, 8'h41);
        drain();
        repeat (20) @(negedge clk);
        rd_chk("R6 stays zero", S_CURR, 32'h0);

        // R2: divide codes 0..6, start count 3
        for (int code = 0; code < 7; code++) begin
            wr(S_DIV, ((code >> 2) << 3) | (code & 3), e0);
            wr(S_INIT, 32'd3, e0);
            expect_irq("R2 divide code", e0 + 3 * (1 << (code + 1)), 8'h41);
            drain();
        end

        // R5: live read while running, write to live count ignored
        wr(S_ENTRY, 32'h0000_0077, e0);
        wr(S_DIV, 32'h0, e0);
        wr(S_INIT, 32'd20, e0);
        expect_irq("R5 run-down", e0 + 40, 8'h77);
        while (cyc < e0 + 7) @(negedge clk);
        rd_chk("R5 live count", S_CURR, 32'd17);
        wr(S_CURR, 32'd5, e1);
        rd_chk("R5 write ignored", S_CURR, 32'd16);
        rd_chk("R5 start count kept", S_INIT, 32'd20);
        drain();

        // R4: restart abandons old count and clears prescaler phase (divide by 8)
        wr(S_DIV, 32'h0000_0002, e0);
        wr(S_INIT, 32'd10, e0);
        repeat (5) @(negedge clk);
        wr(S_INIT, 32'd2, e1);
        expect_irq("R4 restart", e1 + 16, 8'h77);
        drain();
        repeat (70) @(negedge clk);

        // R7: periodic, divide by 4, start count 3, vector 0x52
        wr(S_ENTRY, 32'h0002_0052, e0);
        wr(S_DIV, 32'h0000_0001, e0);
        wr(S_INIT, 32'd3, e0);
        expect_irq("R7 periodic 1", e0 + 12, 8'h52);
        expect_irq("R7 periodic 2", e0 + 24, 8'h52);
        expect_irq("R7 periodic 3", e0 + 36, 8'h52);
        while (cyc < e0 + 14) @(negedge clk);
        rd_chk("R7 reloaded", S_CURR, 32'd3);
        while (cyc < e0 + 40) @(negedge clk);
        // R9: zero start count stops a periodic run
        wr(S_INIT, 32'd0, e1);
        repeat (60) @(negedge clk);
        rd_chk("R9 stopped", S_CURR, 32'd0);

        // R8: masked expiry, counting still completes
        wr(S_ENTRY, 32'h0001_0033, e0);
        wr(S_DIV, 32'h0000_000B, e0);
        wr(S_INIT, 32'd4, e0);
        repeat (8) @(negedge clk);
        rd_chk("R8 counted down", S_CURR, 32'd0);

        // R9: zero start count with unmasked entry
        wr(S_ENTRY, 32'h0000_0033, e0);
        wr(S_INIT, 32'd0, e0);
        repeat (30) @(negedge clk);
        rd_chk("R9 live zero", S_CURR, 32'd0);
        rd_chk("R9 start zero", S_INIT, 32'd0);
        drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule